// File: doc/BRIEF.md
# Double-Buffered Record Address Generator

This block hands out memory start addresses for a stream of incoming records that land in two alternating buffers. Software supplies a base address for each buffer, the number of records a buffer holds, the address step between records and the record length. Two optional header words, a timestamp and a length word, enlarge the space a record needs. Each record-start strobe produces one start address in the buffer currently being filled. Each record-done strobe counts one stored record against that buffer.

When a buffer holds its programmed number of records, the block reports it full and moves to the other buffer, provided that buffer has been rearmed. Rearming takes both a fresh base write and an acknowledge of its full event. If the other buffer has not been rearmed, the block reports an overrun and stops capturing. Capture resumes only on a software start pulse while at least one buffer is rearmed. A stride too small for the record, or a zero record count, is a configuration error, and capture cannot start while it holds.

Top module: `dbuf_rec_addr_gen`

## Requirements
- R1: After reset, capture_en, overrun, rec_addr_valid and buf_full are 0, both record counts are 0, buf_sel is 0, and both buffers are treated as rearmed.
- R2: cfg_err is 1 exactly when cfg_size is 0 or cfg_stride < cfg_rec_size + 4·cfg_tstamp + 4·cfg_varlen. A start pulse while cfg_err is 1 leaves capture_en at 0.
- R3: A start pulse while not capturing, with cfg_err at 0 and a rearmed buffer, sets capture_en one cycle later. It selects buffer 0 if that buffer is rearmed and otherwise buffer 1, and clears that buffer's count. The first address issued is that buffer's base.
- R4: Each rec_start while capturing gives rec_addr_valid high for one cycle, one cycle later. rec_addr is the previous start address plus cfg_stride.
- R5: rec_start while capture_en is 0 issues no address: rec_addr_valid stays 0.
- R6: Each rec_done while capturing increments the record count of the selected buffer by one, visible one cycle later.
- R7: The rec_done that brings the selected buffer's count to cfg_size pulses buf_full for one cycle, one cycle later. Bit 0 is buffer 0 and bit 1 is buffer 1. If the other buffer is rearmed, buf_sel switches to it, its count restarts at 0 and the next address is its base.
- R8: A buffer becomes rearmed only after both a base_wr pulse and a full_ack pulse for it since it was last selected. Bit i of each of these inputs refers to buffer i. One of the two alone does not rearm it.
- R9: When the filling buffer's partner is not rearmed, overrun goes to 1 and capture_en to 0, both one cycle after the fill. No further addresses are issued.
- R10: After an overrun, a start pulse with no rearmed buffer changes nothing. A start pulse with a rearmed buffer clears overrun and resumes capture.
- R11: A rec_start in the same cycle as the filling rec_done that switches buffers receives the new buffer's base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_base0 | input | ADDR_W | Base address of buffer 0 |
| cfg_base1 | input | ADDR_W | Base address of buffer 1 |
| base_wr | input | 2 | Per-buffer pulse: base register rewritten |
| full_ack | input | 2 | Per-buffer pulse: full event acknowledged |
| cfg_size | input | CNT_W | Records per buffer |
| cfg_stride | input | STRIDE_W | Address step between record starts |
| cfg_rec_size | input | STRIDE_W | Record payload length in bytes |
| cfg_tstamp | input | 1 | Timestamp word prepended |
| cfg_varlen | input | 1 | Length word prepended |
| start | input | 1 | Software start/restart pulse |
| rec_start | input | 1 | Record start strobe |
| rec_done | input | 1 | Record stored strobe |
| rec_addr | output | ADDR_W | Start address of the latest record |
| rec_addr_valid | output | 1 | One-cycle pulse with a new rec_addr |
| buf_sel | output | 1 | Buffer being filled |
| rec_cnt0 | output | CNT_W | Records stored in buffer 0 |
| rec_cnt1 | output | CNT_W | Records stored in buffer 1 |
| buf_full | output | 2 | One-cycle full event per buffer |
| overrun | output | 1 | Sticky overrun flag |
| capture_en | output | 1 | Capture active |
| cfg_err | output | 1 | Configuration error |

## Verification
A wrong rearm flag shows within one record period after a buffer fills. The block then either switches into a buffer that software has not released, so the next rec_addr falls on a stale base, or it raises overrun while capture should go on. A record counter that is off by one moves the buf_full pulse and the buffer switch by one record, so the address sequence breaks at the buffer boundary. A pointer error shows on the next rec_addr_valid as an address that is not base plus a multiple of the stride.

// File: rtl/rag_pkg.sv
package rag_pkg;

    typedef enum logic {
        BUF_A = 1'b0,
        BUF_B = 1'b1
    } buf_id_e;

    localparam int NUM_BUFS = 2;
    localparam int HDR_WORD_BYTES = 4;

    function automatic buf_id_e partner_of(buf_id_e id);
        return (id == BUF_A) ? BUF_B : BUF_A;
    endfunction

    function automatic logic [NUM_BUFS-1:0] one_hot_of(buf_id_e id);
        logic [NUM_BUFS-1:0] v;
        v = '0;
        v[id] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/rag_cfg_check.sv
module rag_cfg_check #(
    parameter int STRIDE_W = 16,
    parameter int CNT_W    = 16
) (
    input  logic [STRIDE_W-1:0] stride,
    input  logic [STRIDE_W-1:0] rec_size,
    input  logic                tstamp,
    input  logic                varlen,
    input  logic [CNT_W-1:0]    size,
    output logic                err
);
    import rag_pkg::*;

    localparam int EXT_W = STRIDE_W + 2;

    logic [EXT_W-1:0] need;
    logic [EXT_W-1:0] have;

    always_comb begin
        need = {2'b00, rec_size};
        if (tstamp) need = need + EXT_W'(HDR_WORD_BYTES);
        if (varlen) need = need + EXT_W'(HDR_WORD_BYTES);
        have = {2'b00, stride};
        err  = (have < need) || (size == '0);
    end

    always_comb begin
        if (!err) begin
            assert_cfg_ok_R2: assert ((size != '0) && ({2'b00, stride} >= {2'b00, rec_size}));
        end
    end

endmodule

// File: rtl/rag_arm_track.sv
module rag_arm_track #(
    parameter int NBUF = rag_pkg::NUM_BUFS
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NBUF-1:0] base_wr,
    input  logic [NBUF-1:0] full_ack,
    input  logic [NBUF-1:0] claim,
    output logic [NBUF-1:0] ready
);

    for (genvar i = 0; i < NBUF; i++) begin : g_buf
        logic base_seen_q;
        logic ack_seen_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                base_seen_q <= 1'b1;
                ack_seen_q  <= 1'b1;
            end else if (claim[i]) begin
                base_seen_q <= 1'b0;
                ack_seen_q  <= 1'b0;
            end else begin
                if (base_wr[i])  base_seen_q <= 1'b1;
                if (full_ack[i]) ack_seen_q  <= 1'b1;
            end
        end

        assign ready[i] = base_seen_q & ack_seen_q;

        // R8: a buffer only ever gets claimed while it is rearmed
        assert_claim_armed_R8: assert property (@(posedge clk) disable iff (rst)
            claim[i] |-> ready[i]);

        // R8: a claimed buffer is not rearmed in the following cycle
        assert_claim_clears_R8: assert property (@(posedge clk) disable iff (rst)
            claim[i] |=> !ready[i]);
    end

endmodule

// File: rtl/rag_seq.sv
module rag_seq #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] base0,
    input  logic [ADDR_W-1:0] base1,
    input  logic [CNT_W-1:0]  size,
    input  logic [STRIDE_W-1:0] stride,
    input  logic              cfg_err,
    input  logic [1:0]        ready,
    input  logic              start,
    input  logic              rec_start,
    input  logic              rec_done,
    output logic [ADDR_W-1:0] rec_addr,
    output logic              rec_addr_valid,
    output logic              buf_sel,
    output logic [CNT_W-1:0]  cnt0,
    output logic [CNT_W-1:0]  cnt1,
    output logic [1:0]        buf_full,
    output logic              overrun,
    output logic              capture_en,
    output logic [1:0]        claim
);
    import rag_pkg::*;

    localparam int CW1 = CNT_W + 1;

    buf_id_e           sel_q;
    logic              capture_q;
    logic              overrun_q;
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  cnt_q [NUM_BUFS];
    logic [ADDR_W-1:0] addr_q;
    logic              valid_q;
    logic [1:0]        full_q;

    logic [ADDR_W-1:0] base_arr [NUM_BUFS];
    buf_id_e           oth;
    buf_id_e           start_sel;
    logic [CNT_W-1:0]  cnt_cur;
    logic              fill, sw_ok, ovr_hit, start_ok, issue;
    logic [ADDR_W-1:0] ptr_eff;
    logic [ADDR_W-1:0] stride_ext;

    always_comb begin
        base_arr[0] = base0;
        base_arr[1] = base1;
        oth         = partner_of(sel_q);
        start_sel   = ready[0] ? BUF_A : BUF_B;
        cnt_cur     = cnt_q[sel_q];
        stride_ext  = ADDR_W'(stride);
        fill        = capture_q && rec_done &&
                      ({1'b0, cnt_cur} + CW1'(1) == {1'b0, size});
        sw_ok       = fill && ready[oth];
        ovr_hit     = fill && !ready[oth];
        start_ok    = start && !capture_q && !cfg_err && (|ready);
        issue       = capture_q && rec_start && !ovr_hit;
        ptr_eff     = sw_ok ? base_arr[oth] : ptr_q;
        if (start_ok)   claim = one_hot_of(start_sel);
        else if (sw_ok) claim = one_hot_of(oth);
        else            claim = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q     <= BUF_A;
            capture_q <= 1'b0;
            overrun_q <= 1'b0;
            ptr_q     <= '0;
            cnt_q[0]  <= '0;
            cnt_q[1]  <= '0;
            addr_q    <= '0;
            valid_q   <= 1'b0;
            full_q    <= '0;
        end else begin
            valid_q <= issue;
            if (issue) addr_q <= ptr_eff;
            full_q  <= fill ? one_hot_of(sel_q) : 2'b00;

            if (start_ok) begin
                capture_q        <= 1'b1;
                overrun_q        <= 1'b0;
                sel_q            <= start_sel;
                ptr_q            <= base_arr[start_sel];
                cnt_q[start_sel] <= '0;
            end else if (capture_q) begin
                if (rec_done) cnt_q[sel_q] <= cnt_cur + CNT_W'(1);
                if (sw_ok) begin
                    sel_q      <= oth;
                    cnt_q[oth] <= '0;
                    ptr_q      <= base_arr[oth] + (rec_start ? stride_ext : '0);
                end else if (ovr_hit) begin
                    capture_q <= 1'b0;
                    overrun_q <= 1'b1;
                end else if (rec_start) begin
                    ptr_q <= ptr_q + stride_ext;
                end
            end
        end
    end

    assign rec_addr       = addr_q;
    assign rec_addr_valid = valid_q;
    assign buf_sel        = sel_q;
    assign cnt0           = cnt_q[0];
    assign cnt1           = cnt_q[1];
    assign buf_full       = full_q;
    assign overrun        = overrun_q;
    assign capture_en     = capture_q;

    // R7: at most one buffer reports full at a time
    assert_full_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(full_q));

    // R9: an overrun leaves capture stopped
    assert_overrun_stops_R9: assert property (@(posedge clk) disable iff (rst)
        overrun_q |-> !capture_q);

    // R5: an address is only issued if capture was on in the cycle before
    assert_valid_needs_capture_R5: assert property (@(posedge clk) disable iff (rst)
        valid_q |-> $past(capture_q));

    // R2 and R3: capture only starts on a clean configuration with a rearmed buffer
    assert_start_gated_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(capture_q) |-> $past(!cfg_err && (|ready)));

endmodule

// File: rtl/dbuf_rec_addr_gen.sv
module dbuf_rec_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int CNT_W    = 16,
    parameter int STRIDE_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cfg_base0,
    input  logic [ADDR_W-1:0]   cfg_base1,
    input  logic [1:0]          base_wr,
    input  logic [1:0]          full_ack,
    input  logic [CNT_W-1:0]    cfg_size,
    input  logic [STRIDE_W-1:0] cfg_stride,
    input  logic [STRIDE_W-1:0] cfg_rec_size,
    input  logic                cfg_tstamp,
    input  logic                cfg_varlen,
    input  logic                start,
    input  logic                rec_start,
    input  logic                rec_done,
    output logic [ADDR_W-1:0]   rec_addr,
    output logic                rec_addr_valid,
    output logic                buf_sel,
    output logic [CNT_W-1:0]    rec_cnt0,
    output logic [CNT_W-1:0]    rec_cnt1,
    output logic [1:0]          buf_full,
    output logic                overrun,
    output logic                capture_en,
    output logic                cfg_err
);

    logic [1:0] ready;
    logic [1:0] claim;

    rag_cfg_check #(.STRIDE_W(STRIDE_W), .CNT_W(CNT_W)) i_cfg (
        .stride   (cfg_stride),
        .rec_size (cfg_rec_size),
        .tstamp   (cfg_tstamp),
        .varlen   (cfg_varlen),
        .size     (cfg_size),
        .err      (cfg_err)
    );

    rag_arm_track #(.NBUF(2)) i_arm (
        .clk      (clk),
        .rst      (rst),
        .base_wr  (base_wr),
        .full_ack (full_ack),
        .claim    (claim),
        .ready    (ready)
    );

    rag_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .STRIDE_W(STRIDE_W)) i_seq (
        .clk            (clk),
        .rst            (rst),
        .base0          (cfg_base0),
        .base1          (cfg_base1),
        .size           (cfg_size),
        .stride         (cfg_stride),
        .cfg_err        (cfg_err),
        .ready          (ready),
        .start          (start),
        .rec_start      (rec_start),
        .rec_done       (rec_done),
        .rec_addr       (rec_addr),
        .rec_addr_valid (rec_addr_valid),
        .buf_sel        (buf_sel),
        .cnt0           (rec_cnt0),
        .cnt1           (rec_cnt1),
        .buf_full       (buf_full),
        .overrun        (overrun),
        .capture_en     (capture_en),
        .claim          (claim)
    );

endmodule

// File: tb/test_dbuf_rec_addr_gen.sv
`timescale 1ns/1ps
module test_dbuf_rec_addr_gen;

    localparam int AW = 32;
    localparam int CW = 16;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [AW-1:0] cfg_base0 = 32'h1000;
    logic [AW-1:0] cfg_base1 = 32'h8000;
    logic [1:0]    base_wr = '0;
    logic [1:0]    full_ack = '0;
    logic [CW-1:0] cfg_size = 16'd3;
    logic [SW-1:0] cfg_stride = 16'h20;
    logic [SW-1:0] cfg_rec_size = 16'h18;
    logic          cfg_tstamp = 1'b1;
    logic          cfg_varlen = 1'b0;
    logic          start = 1'b0;
    logic          rec_start = 1'b0;
    logic          rec_done = 1'b0;
    logic [AW-1:0] rec_addr;
    logic          rec_addr_valid;
    logic          buf_sel;
    logic [CW-1:0] rec_cnt0, rec_cnt1;
    logic [1:0]    buf_full;
    logic          overrun, capture_en, cfg_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dbuf_rec_addr_gen i_dbuf_rec_addr_gen (
        .clk(clk), .rst(rst), .cfg_base0(cfg_base0), .cfg_base1(cfg_base1),
        .base_wr(base_wr), .full_ack(full_ack), .cfg_size(cfg_size),
        .cfg_stride(cfg_stride), .cfg_rec_size(cfg_rec_size),
        .cfg_tstamp(cfg_tstamp), .cfg_varlen(cfg_varlen), .start(start),
        .rec_start(rec_start), .rec_done(rec_done), .rec_addr(rec_addr),
        .rec_addr_valid(rec_addr_valid), .buf_sel(buf_sel),
        .rec_cnt0(rec_cnt0), .rec_cnt1(rec_cnt1), .buf_full(buf_full),
        .overrun(overrun), .capture_en(capture_en), .cfg_err(cfg_err)
    );

    // {stride, rec_size, tstamp, varlen, expected cfg_err}
    localparam logic [34:0] CFG_VEC [6] = '{
        {16'h18, 16'h18, 1'b0, 1'b0, 1'b0},
        {16'h17, 16'h18, 1'b0, 1'b0, 1'b1},
        {16'h1C, 16'h18, 1'b1, 1'b0, 1'b0},
        {16'h1B, 16'h18, 1'b1, 1'b0, 1'b1},
        {16'h20, 16'h18, 1'b1, 1'b1, 1'b0},
        {16'h1F, 16'h18, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic pulse_start();
        start = 1'b1; tick(); start = 1'b0;
    endtask

    task automatic pulse_rec(logic s, logic d);
        rec_start = s; rec_done = d; tick(); rec_start = 1'b0; rec_done = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1 reset state
        chk("R1 capture_en", capture_en, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 valid", rec_addr_valid, 0);
        chk("R1 buf_full", buf_full, 0);
        chk("R1 counts", {rec_cnt0, rec_cnt1}, 0);
        chk("R1 buf_sel", buf_sel, 0);

        // R2 configuration table
        for (int i = 0; i < 6; i++) begin
            cfg_stride   = CFG_VEC[i][34:19];
            cfg_rec_size = CFG_VEC[i][18:3];
            cfg_tstamp   = CFG_VEC[i][2];
            cfg_varlen   = CFG_VEC[i][1];
            tick();
            chk($sformatf("R2 cfg_err vector %0d", i), cfg_err, CFG_VEC[i][0]);
        end
        // last vector is an error: start must be refused (R2)
        pulse_start();
        tick();
        chk("R2 start refused", capture_en, 0);
        cfg_stride = 16'h20; cfg_tstamp = 1'b1; cfg_varlen = 1'b0;
        cfg_size = '0;
        tick();
        chk("R2 zero size", cfg_err, 1);
        cfg_size = 16'd3;
        tick();
        chk("R2 clean config", cfg_err, 0);

        // R3 start
        pulse_start();
        chk("R3 capture_en", capture_en, 1);
        chk("R3 buf_sel", buf_sel, 0);
        pulse_rec(1, 0);
        chk("R3 first valid", rec_addr_valid, 1);
        chk("R3 first addr", rec_addr, 32'h1000);
        pulse_rec(0, 1);
        chk("R6 cnt0 one", rec_cnt0, 1);
        chk("R4 valid one cycle", rec_addr_valid, 0);
        pulse_rec(1, 0);
        chk("R4 second addr", rec_addr, 32'h1020);
        pulse_rec(0, 1);
        chk("R6 cnt0 two", rec_cnt0, 2);
        pulse_rec(1, 0);
        chk("R4 third addr", rec_addr, 32'h1040);
        pulse_rec(0, 1);
        chk("R7 buf_full buffer 0", buf_full, 2'b01);
        chk("R7 switch to buffer 1", buf_sel, 1);
        chk("R7 cnt0 at size", rec_cnt0, 3);
        chk("R7 cnt1 restart", rec_cnt1, 0);
        tick();
        chk("R7 full is a pulse", buf_full, 0);
        pulse_rec(1, 0);
        chk("R7 base of buffer 1", rec_addr, 32'h8000);

        // R8: base write only, no ack, for buffer 0
        cfg_base0 = 32'h2000;
        base_wr = 2'b01; tick(); base_wr = 2'b00;
        pulse_rec(0, 1);
        chk("R6 cnt1 one", rec_cnt1, 1);
        pulse_rec(1, 0);
        chk("R4 buffer 1 step", rec_addr, 32'h8020);
        pulse_rec(0, 1);
        pulse_rec(1, 0);
        chk("R4 buffer 1 third", rec_addr, 32'h8040);
        pulse_rec(0, 1);
        chk("R8 R9 overrun without ack", overrun, 1);
        chk("R9 capture stopped", capture_en, 0);
        chk("R7 buf_full buffer 1", buf_full, 2'b10);
        pulse_rec(1, 0);
        chk("R5 no address when idle", rec_addr_valid, 0);
        pulse_start();
        chk("R10 start without rearm", capture_en, 0);
        chk("R10 overrun kept", overrun, 1);

        // R10 rearm buffer 0 and restart
        full_ack = 2'b01; tick(); full_ack = 2'b00;
        pulse_start();
        chk("R10 resumed", capture_en, 1);
        chk("R10 overrun cleared", overrun, 0);
        chk("R10 buf_sel 0", buf_sel, 0);
        chk("R3 cnt0 cleared", rec_cnt0, 0);
        pulse_rec(1, 0);
        chk("R10 new base 0", rec_addr, 32'h2000);
        pulse_rec(0, 1);
        cfg_base1 = 32'h9000;
        base_wr = 2'b10; full_ack = 2'b10; tick(); base_wr = 2'b00; full_ack = 2'b00;
        pulse_rec(1, 0);
        pulse_rec(0, 1);
        pulse_rec(1, 0);
        chk("R4 buffer 0 third", rec_addr, 32'h2040);

        // R11 coincident filling done and start
        pulse_rec(1, 1);
        chk("R11 valid", rec_addr_valid, 1);
        chk("R11 new base", rec_addr, 32'h9000);
        chk("R11 buf_sel", buf_sel, 1);
        chk("R11 cnt1", rec_cnt1, 0);
        chk("R11 overrun clear", overrun, 0);
        pulse_rec(1, 0);
        chk("R11 next step", rec_addr, 32'h9020);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule